// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Shared Prescaler

The block is an 8-bit up-counter that software can read and load at any time. It counts either a one-cycle instruction tick or edges on an external timer pin. The pin is synchronised first, and a control field chooses whether rising or falling edges count. When the counter wraps from its top value to zero, the block raises a one-cycle overflow pulse.

A single free-running prescaler is shared between the timer and a watchdog. The block applies it to only one of them at a time. When the prescaler belongs to the timer, it divides the timer's count events by 2, 4 and so on up to 256. When it belongs to the watchdog, it divides a raw watchdog tick by 1, 2 and so on up to 128, and the timer then counts every event of its source. Any software load of the counter also clears the prescaler.

The control input is a 6-bit field:

| Bits | Meaning |
|---|---|
| [2:0] | Division code |
| [3] | Prescaler owner: 0 = timer, 1 = watchdog |
| [4] | Edge select: 0 = rising, 1 = falling |
| [5] | Source select: 0 = instruction tick, 1 = pin |

Whenever bit 5 is 1, the block also drives a request that forces the direction control of the timer pin to input.

Top module: `tmr_prescaled`

## Requirements
- R1: While reset is held, and on release, the count reads 0 and the overflow pulse is 0. The prescaler also starts from zero, so the first timer increment needs the full division ratio.
- R2: With load high, the count takes the load value at the next clock edge. The load wins over any increment in the same cycle, and it clears the prescaler.
- R3: When ctrl[5]=0 and ctrl[3]=0, the count advances once for every 2^(code+1) instruction ticks, where code is ctrl[2:0].
- R4: When ctrl[5]=1 and ctrl[4]=0, each rising edge of the pin counts. The count shows the new value on the third clock edge after the pin changes, and falling edges have no effect.
- R5: When ctrl[5]=1 and ctrl[4]=1, each falling edge of the pin counts and rising edges have no effect.
- R6: When ctrl[3]=1, the timer advances on every event of its selected source. The watchdog tick output pulses on every 2^code-th raw watchdog tick and is 0 whenever the raw tick is 0.
- R7: When ctrl[3]=0, the watchdog tick output equals the raw watchdog tick.
- R8: The overflow pulse is high for exactly the one cycle in which the count first reads 0 after an increment from 0xFF.
- R9: The pin-input request output equals ctrl[5].
- R10: Without a load, the count changes by at most +1 per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 6 | Control field (code, owner, edge, source) |
| instr_tick | input | 1 | One-cycle instruction-cycle tick |
| tmr_pin | input | 1 | External timer pin, asynchronous |
| wdt_raw_tick | input | 1 | Undivided watchdog base tick |
| cnt_load | input | 1 | Software write strobe for the count |
| cnt_wdata | input | 8 | Value to load |
| cnt_q | output | 8 | Current count |
| ovf_pulse | output | 1 | One-cycle overflow event |
| wdt_tick | output | 1 | Tick passed on to the watchdog |
| pin_force_in | output | 1 | Request to force the timer pin to input |

## Verification
The assertions assume that no count source delivers more than one event per cycle. They also assume that the pin is low when reset is released, since a pin already high at release reads as a rising edge. The stimulus keeps ticks and loads as single-cycle strobes driven on the falling clock edge. It holds the pin low through reset and waits well beyond the three-edge synchroniser latency between pin changes. Control changes are made only while every source is idle.

// File: rtl/tmr_prescaled.sv
module tmr_prescaled #(
  parameter int CNT_W  = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W+2:0] ctrl,
  input  logic              instr_tick,
  input  logic              tmr_pin,
  input  logic              wdt_raw_tick,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ovf_pulse,
  output logic              wdt_tick,
  output logic              pin_force_in
);
  localparam int PW    = 2 ** CODE_W;
  localparam int B_OWN = CODE_W;
  localparam int B_EDG = CODE_W + 1;
  localparam int B_SRC = CODE_W + 2;
  localparam logic [PW:0] ONE = (PW+1)'(1);

  wire [CODE_W-1:0] code   = ctrl[CODE_W-1:0];
  wire              to_wdt = ctrl[B_OWN];
  wire              fall   = ctrl[B_EDG];
  wire              ext    = ctrl[B_SRC];

  logic sync1, sync2, sync_d;
  logic [PW-1:0] pre_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) {sync1, sync2, sync_d} <= '0;
    else        {sync1, sync2, sync_d} <= {tmr_pin, sync1, sync2};
  end

  wire edge_ev = fall ? (sync_d & ~sync2) : (sync2 & ~sync_d);
  wire src_ev  = ext ? edge_ev : instr_tick;

  wire [PW:0]    tmr_span = ONE << ({1'b0, code} + (CODE_W+1)'(1));
  wire [PW:0]    wdt_span = ONE << code;
  wire [PW-1:0]  mask     = to_wdt ? PW'(wdt_span - ONE) : PW'(tmr_span - ONE);
  wire           pre_in   = to_wdt ? wdt_raw_tick : src_ev;
  wire           pre_out  = pre_in & ((pre_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || cnt_load) pre_cnt <= '0;
    else if (pre_in)        pre_cnt <= pre_cnt + PW'(1);
  end

  wire tmr_inc = to_wdt ? src_ev : pre_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= tmr_inc & ~cnt_load & (&cnt_q);
      if (cnt_load)     cnt_q <= cnt_wdata;
      else if (tmr_inc) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign wdt_tick     = to_wdt ? pre_out : wdt_raw_tick;
  assign pin_force_in = ext;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> (cnt_q == $past(cnt_wdata) && pre_cnt == '0));

  assert_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_load |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_ovf_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (cnt_q == '0 && $past(cnt_q) == {CNT_W{1'b1}}));

  assert_ovf_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

  assert_wdt_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (to_wdt && !wdt_raw_tick) |-> !wdt_tick);
endmodule

// File: tb/tb_tmr_prescaled.sv
`timescale 1ns/1ps
module tb_tmr_prescaled;
  logic       clk = 0, rst_n = 0;
  logic [5:0] ctrl = 0;
  logic       instr_tick = 0, tmr_pin = 0, wdt_raw_tick = 0, cnt_load = 0;
  logic [7:0] cnt_wdata = 0;
  logic [7:0] cnt_q;
  logic       ovf_pulse, wdt_tick, pin_force_in;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  tmr_prescaled dut (.clk, .rst_n, .ctrl, .instr_tick, .tmr_pin, .wdt_raw_tick,
    .cnt_load, .cnt_wdata, .cnt_q, .ovf_pulse, .wdt_tick, .pin_force_in);

  always #2.5 clk = ~clk;

  localparam int NV = 7;
  localparam int V_CODE [NV] = '{0, 1, 2, 7, 7, 3, 0};
  localparam int V_OWN  [NV] = '{0, 0, 0, 0, 0, 1, 0};
  localparam int V_N    [NV] = '{10, 12, 20, 255, 256, 37, 7};
  localparam int V_EXP  [NV] = '{5, 3, 2, 0, 1, 37, 3};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk) begin cnt_load = 1; cnt_wdata = v; end
    @(negedge clk) cnt_load = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) @(negedge clk) instr_tick = 1;
    @(negedge clk) instr_tick = 0;
  endtask

  task automatic wdt_count(int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) wdt_raw_tick = 1;
      #1 if (wdt_tick) pulses++;
    end
    @(negedge clk) wdt_raw_tick = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", cnt_q, 0);
    chk("R1 ovf in reset", ovf_pulse, 0);
    @(negedge clk) rst_n = 1;
    chk("R1 count after release", cnt_q, 0);
    ctrl = 6'b000000;
    ticks(1);
    chk("R1 prescaler starts empty", cnt_q, 0);
    ticks(1);
    chk("R1 first increment after two ticks", cnt_q, 1);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk) ctrl = {2'b00, V_OWN[v][0], V_CODE[v][2:0]};
      load(8'd0);
      ticks(V_N[v]);
      chk($sformatf("R3/R6 vector %0d", v), cnt_q, V_EXP[v]);
    end

    ctrl = 6'b000001;
    load(8'd0);
    ticks(3);
    chk("R2 partial prescale", cnt_q, 0);
    load(8'h10);
    ticks(1);
    chk("R2 load clears prescaler", cnt_q, 8'h10);
    ticks(3);
    chk("R2 full ratio after load", cnt_q, 8'h11);

    ctrl = 6'b001000;
    load(8'h20);
    @(negedge clk) begin instr_tick = 1; cnt_load = 1; cnt_wdata = 8'h77; end
    @(negedge clk) begin instr_tick = 0; cnt_load = 0; end
    chk("R2 load beats increment", cnt_q, 8'h77);

    load(8'hFE);
    ticks(1);
    chk("R8 no ovf at FF", ovf_pulse, 0);
    chk("R8 count FF", cnt_q, 8'hFF);
    ticks(1);
    chk("R8 ovf on wrap", ovf_pulse, 1);
    chk("R8 count wraps to 0", cnt_q, 0);
    @(negedge clk);
    chk("R8 ovf single cycle", ovf_pulse, 0);

    @(negedge clk) ctrl = 6'b101000;
    chk("R9 force input on pin source", pin_force_in, 1);
    load(8'd5);
    @(negedge clk) tmr_pin = 1;
    @(negedge clk); @(negedge clk);
    chk("R4 no count before third edge", cnt_q, 5);
    @(negedge clk);
    chk("R4 rising edge counted", cnt_q, 6);
    @(negedge clk) tmr_pin = 0;
    repeat (4) @(negedge clk);
    chk("R4 falling edge ignored", cnt_q, 6);
    ctrl = 6'b111000;
    @(negedge clk) tmr_pin = 1;
    repeat (4) @(negedge clk);
    chk("R5 rising edge ignored", cnt_q, 6);
    @(negedge clk) tmr_pin = 0;
    repeat (4) @(negedge clk);
    chk("R5 falling edge counted", cnt_q, 7);
    instr_tick = 0;
    ticks(3);
    chk("R5 instruction ticks ignored on pin source", cnt_q, 7);

    @(negedge clk) ctrl = 6'b001010;
    chk("R9 no force on tick source", pin_force_in, 0);
    load(8'd0);
    wdt_count(8, p);
    chk("R6 wdt divide by 4", p, 2);
    chk("R6 timer unaffected by wdt ticks", cnt_q, 0);
    @(negedge clk) ctrl = 6'b001000;
    load(8'd0);
    wdt_count(5, p);
    chk("R6 wdt divide by 1", p, 5);
    @(negedge clk) ctrl = 6'b000111;
    wdt_count(3, p);
    chk("R7 wdt passthrough", p, 3);

    load(8'h55);
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    chk("R1 reset mid-run", cnt_q, 0);
    finish_run();
  end
endmodule